// File: doc/BRIEF.md
# Base Address Window Tracker

This block keeps track of the address window that each base address register of a configuration header actually decodes. It watches up to six base registers and one expansion-ROM register. For each region it also takes a power-of-two size, an I/O-or-memory type, and the I/O-enable and memory-enable bits of the command register. From these it works out an effective base for each region. A region that is switched off or whose window breaks an address rule is treated as unmapped.

The tracker holds the window currently in force for each region. It compares that window with the one the inputs now ask for. When they differ, it reports the change to the rest of the system as one-cycle strobes. The old window is released first, and the new one is claimed after it. Regions are handled one at a time, lowest index first. Address routing of real transactions is left to the logic that consumes the strobes.

Top module: `bar_window_tracker`

## Requirements
- R1: After reset every region reads unmapped: the valid bit is 0, the base is all ones, and no strobe is raised.
- R2: An enabled, legal region is mapped at the register value ANDed with the inverse of (size - 1).
- R3: A region whose I/O-type bit is 1 decodes only while the I/O enable is 1. Any other region decodes only while the memory enable is 1. Clearing an enable unmaps only the regions of its own type.
- R4: The expansion-ROM region is region index NUM_BARS. It is always memory type, whatever its type bit says. It decodes only while bit 0 of its register is 1.
- R5: A window whose masked base is zero is never mapped.
- R6: A window whose end (base + size - 1) is not above its base is never mapped. A memory window whose end is all ones is never mapped.
- R7: An I/O window whose end is at or above 0x10000 is never mapped.
- R8: A region of size zero stays unmapped and never raises a strobe, whatever its register holds.
- R9: A change of effective base raises an unmap strobe with the old base when the old window was mapped. When the new window is legal, a map strobe with the new base follows in the very next cycle. The two strobes are never high together.
- R10: A register change that leaves the effective base the same raises no strobe.
- R11: When several regions change at once, their strobes come out in ascending region index order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_io_en_i | input | 1 | Command register I/O decode enable |
| cmd_mem_en_i | input | 1 | Command register memory decode enable |
| bar_val_i | input | NREG*ADDR_W | Register contents; region n in bits [n*ADDR_W +: ADDR_W] |
| region_size_i | input | NREG*ADDR_W | Region size, a power of two or zero, packed like bar_val_i |
| region_is_io_i | input | NREG | 1 = I/O region, 0 = memory region |
| eff_base_o | output | NREG*ADDR_W | Base currently mapped per region, all ones when unmapped |
| eff_valid_o | output | NREG | Region currently mapped |
| ev_map_o | output | 1 | One-cycle strobe: window claimed |
| ev_unmap_o | output | 1 | One-cycle strobe: window released |
| ev_idx_o | output | IDX_W | Region index of the strobe |
| ev_addr_o | output | ADDR_W | Base address of the strobe |

## Verification
The bench goes after the windows that sit right on a rule's edge. One is an I/O window ending exactly at 0xFFFF, which must map, while the same window moved up one step must unmap. Another is a memory window ending at all ones, and another is a ROM window with its enable bit clear. A design that used the wrong comparison at either limit would claim or drop one of these windows. The bench also changes several regions in a single cycle and moves a base within a region. A scan in the wrong order, or a map strobe sent without its unmap one cycle before, would then show up as a strobe out of order. Changes to the low bits below the size mask are included, so a design that compared raw register values would send strobes that should not exist.

// File: rtl/bwt_pkg.sv
package bwt_pkg;
   typedef enum logic [0:0] {
      SQ_SCAN = 1'b0,
      SQ_MAP  = 1'b1
   } sq_state_e;

   localparam int unsigned MAX_BARS = 6;
endpackage

// File: rtl/bwt_window.sv
module bwt_window #(
   parameter int unsigned       ADDR_W   = 32,
   parameter bit                IS_ROM   = 1'b0,
   parameter logic [ADDR_W-1:0] IO_LIMIT = 'h10000
) (
   input  logic [ADDR_W-1:0] bar_i,
   input  logic [ADDR_W-1:0] size_i,
   input  logic              is_io_i,
   input  logic              io_en_i,
   input  logic              mem_en_i,
   output logic [ADDR_W-1:0] tgt_base_o,
   output logic              tgt_ok_o
);
   localparam logic [ADDR_W-1:0] ONES = '1;

   logic [ADDR_W-1:0] lo_mask;
   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] last;
   logic              io_kind;
   logic              enabled;
   logic              legal;

   assign lo_mask = size_i - 1'b1;
   assign base    = bar_i & ~lo_mask;
   assign last    = base + lo_mask;

   generate
      if (IS_ROM) begin : g_rom
         assign io_kind = 1'b0;
         assign enabled = mem_en_i & bar_i[0];
      end else begin : g_bar
         assign io_kind = is_io_i;
         assign enabled = is_io_i ? io_en_i : mem_en_i;
      end
   endgenerate

   always_comb begin
      legal = (base != '0) && (last > base);
      if (io_kind) legal = legal && (last < IO_LIMIT);
      else         legal = legal && (last != ONES);
   end

   assign tgt_ok_o   = (size_i != '0) && enabled && legal;
   assign tgt_base_o = tgt_ok_o ? base : ONES;
endmodule

// File: rtl/bwt_pick.sv
module bwt_pick #(
   parameter int unsigned N     = 7,
   parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req_i,
   output logic             found_o,
   output logic [IDX_W-1:0] idx_o
);
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (req_i[k]) begin
            found_o = 1'b1;
            idx_o   = IDX_W'(k);
         end
      end
   end
endmodule

// File: rtl/bwt_sequencer.sv
module bwt_sequencer
   import bwt_pkg::*;
#(
   parameter int unsigned NREG   = 7,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned IDX_W  = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NREG*ADDR_W-1:0] tgt_base_i,
   input  logic [NREG-1:0]        tgt_ok_i,
   output logic [NREG*ADDR_W-1:0] cur_base_o,
   output logic                   ev_map_o,
   output logic                   ev_unmap_o,
   output logic [IDX_W-1:0]       ev_idx_o,
   output logic [ADDR_W-1:0]      ev_addr_o
);
   localparam logic [ADDR_W-1:0] ONES = '1;

   logic [ADDR_W-1:0] cur  [NREG];
   logic [ADDR_W-1:0] tgt  [NREG];
   logic [NREG-1:0]   differs;
   logic              found;
   logic [IDX_W-1:0]  pk;
   logic [ADDR_W-1:0] pend_base;
   sq_state_e         state;

   genvar g;
   generate
      for (g = 0; g < NREG; g++) begin : g_reg
         assign tgt[g] = tgt_ok_i[g] ? tgt_base_i[g*ADDR_W +: ADDR_W] : ONES;
         assign differs[g] = (cur[g] != tgt[g]);
         assign cur_base_o[g*ADDR_W +: ADDR_W] = cur[g];

         assert_never_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            cur[g] != '0);
      end
   endgenerate

   bwt_pick #(.N(NREG), .IDX_W(IDX_W)) u_pick (
      .req_i   (differs),
      .found_o (found),
      .idx_o   (pk)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < NREG; k++) cur[k] <= ONES;
         state      <= SQ_SCAN;
         ev_map_o   <= 1'b0;
         ev_unmap_o <= 1'b0;
         ev_idx_o   <= '0;
         ev_addr_o  <= '0;
         pend_base  <= ONES;
      end else begin
         ev_map_o   <= 1'b0;
         ev_unmap_o <= 1'b0;
         case (state)
            SQ_SCAN: begin
               if (found) begin
                  ev_idx_o <= pk;
                  if (cur[pk] != ONES) begin
                     ev_unmap_o <= 1'b1;
                     ev_addr_o  <= cur[pk];
                     cur[pk]    <= ONES;
                     if (tgt[pk] != ONES) begin
                        pend_base <= tgt[pk];
                        state     <= SQ_MAP;
                     end
                  end else begin
                     ev_map_o  <= 1'b1;
                     ev_addr_o <= tgt[pk];
                     cur[pk]   <= tgt[pk];
                  end
               end
            end
            SQ_MAP: begin
               ev_map_o      <= 1'b1;
               ev_addr_o     <= pend_base;
               cur[ev_idx_o] <= pend_base;
               state         <= SQ_SCAN;
            end
            default: state <= SQ_SCAN;
         endcase
      end
   end

   assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev_map_o && ev_unmap_o));

   assert_unmap_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ev_unmap_o |-> (cur[ev_idx_o] == ONES) && (ev_addr_o != ONES));

   assert_map_claims_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_map_o |-> (cur[ev_idx_o] == ev_addr_o) && (ev_addr_o != ONES));

   assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == SQ_SCAN && !$past(found)) |-> !(ev_map_o || ev_unmap_o));
endmodule

// File: rtl/bar_window_tracker.sv
module bar_window_tracker #(
   parameter int unsigned       NUM_BARS = 6,
   parameter bit                HAS_ROM  = 1'b1,
   parameter int unsigned       ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] IO_LIMIT = 'h10000,
   localparam int unsigned      NREG     = NUM_BARS + (HAS_ROM ? 1 : 0),
   localparam int unsigned      IDX_W    = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cmd_io_en_i,
   input  logic                   cmd_mem_en_i,
   input  logic [NREG*ADDR_W-1:0] bar_val_i,
   input  logic [NREG*ADDR_W-1:0] region_size_i,
   input  logic [NREG-1:0]        region_is_io_i,
   output logic [NREG*ADDR_W-1:0] eff_base_o,
   output logic [NREG-1:0]        eff_valid_o,
   output logic                   ev_map_o,
   output logic                   ev_unmap_o,
   output logic [IDX_W-1:0]       ev_idx_o,
   output logic [ADDR_W-1:0]      ev_addr_o
);
   localparam logic [ADDR_W-1:0] ONES = '1;

   generate
      if (NUM_BARS < 1 || NUM_BARS > bwt_pkg::MAX_BARS) begin : g_bad_count
         $error("bar_window_tracker: NUM_BARS out of range");
      end
      if (ADDR_W < 17 || ADDR_W > 64) begin : g_bad_width
         $error("bar_window_tracker: ADDR_W out of range");
      end
   endgenerate

   logic [NREG*ADDR_W-1:0] tgt_base;
   logic [NREG-1:0]        tgt_ok;

   genvar g;
   generate
      for (g = 0; g < NREG; g++) begin : g_win
         bwt_window #(
            .ADDR_W   (ADDR_W),
            .IS_ROM   (HAS_ROM && (g == NUM_BARS)),
            .IO_LIMIT (IO_LIMIT)
         ) u_win (
            .bar_i      (bar_val_i[g*ADDR_W +: ADDR_W]),
            .size_i     (region_size_i[g*ADDR_W +: ADDR_W]),
            .is_io_i    (region_is_io_i[g]),
            .io_en_i    (cmd_io_en_i),
            .mem_en_i   (cmd_mem_en_i),
            .tgt_base_o (tgt_base[g*ADDR_W +: ADDR_W]),
            .tgt_ok_o   (tgt_ok[g])
         );
         assign eff_valid_o[g] = (eff_base_o[g*ADDR_W +: ADDR_W] != ONES);
      end
   endgenerate

   bwt_sequencer #(.NREG(NREG), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .tgt_base_i (tgt_base),
      .tgt_ok_i   (tgt_ok),
      .cur_base_o (eff_base_o),
      .ev_map_o   (ev_map_o),
      .ev_unmap_o (ev_unmap_o),
      .ev_idx_o   (ev_idx_o),
      .ev_addr_o  (ev_addr_o)
   );

   assert_valid_has_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eff_valid_o[ev_idx_o]) |-> ev_map_o);
endmodule

// File: tb/sim_bar_window_tracker.sv
`timescale 1ns/1ps
module sim_bar_window_tracker;
   localparam int NR = 7;
   localparam int AW = 32;

   typedef struct {
      bit          is_map;
      int          idx;
      logic [31:0] addr;
      bit          b2b;
      string       req;
   } exp_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            io_en = 1'b0, mem_en = 1'b0;
   logic [31:0]     bar [NR];
   logic [31:0]     sz  [NR];
   logic [NR-1:0]   is_io;
   logic [NR*AW-1:0] bar_f, sz_f, base_f;
   logic [NR-1:0]   valid;
   logic            ev_map, ev_unmap;
   logic [2:0]      ev_idx;
   logic [31:0]     ev_addr;

   int   checks = 0, fails = 0;
   bit   done = 1'b0;
   bit   prev_unmap = 1'b0;
   exp_t q[$];
   exp_t e;

   always #5 clk = ~clk;

   always_comb begin
      for (int k = 0; k < NR; k++) begin
         bar_f[k*AW +: AW] = bar[k];
         sz_f[k*AW +: AW]  = sz[k];
      end
   end

   bar_window_tracker u0 (
      .clk(clk), .rst_n(rst_n), .cmd_io_en_i(io_en), .cmd_mem_en_i(mem_en),
      .bar_val_i(bar_f), .region_size_i(sz_f), .region_is_io_i(is_io),
      .eff_base_o(base_f), .eff_valid_o(valid), .ev_map_o(ev_map),
      .ev_unmap_o(ev_unmap), .ev_idx_o(ev_idx), .ev_addr_o(ev_addr)
   );

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (ev_map && ev_unmap) begin
            checks++; fails++;
            $display("FAIL R9: map and unmap together, actual 1/1 expected one of them");
         end
         if (ev_map || ev_unmap) begin
            checks++;
            if (q.size() == 0) begin
               fails++;
               $display("FAIL R10: unexpected strobe map=%0b idx=%0d addr=%h, expected none",
                        ev_map, ev_idx, ev_addr);
            end else begin
               e = q.pop_front();
               if (ev_map != e.is_map || int'(ev_idx) != e.idx || ev_addr != e.addr) begin
                  fails++;
                  $display("FAIL %s: strobe map=%0b idx=%0d addr=%h, expected map=%0b idx=%0d addr=%h",
                           e.req, ev_map, ev_idx, ev_addr, e.is_map, e.idx, e.addr);
               end
               if (e.b2b && !prev_unmap) begin
                  fails++;
                  $display("FAIL R9: map not right after unmap, actual gap expected 1 cycle");
               end
            end
         end
         prev_unmap = ev_unmap;
      end
   end

   task automatic expect_ev(bit m, int i, logic [31:0] a, bit b2b, string r);
      exp_t x;
      x.is_map = m; x.idx = i; x.addr = a; x.b2b = b2b; x.req = r;
      q.push_back(x);
   endtask

   task automatic settle(string r);
      repeat (20) @(posedge clk);
      @(negedge clk);
      checks++;
      if (q.size() != 0) begin
         fails++;
         $display("FAIL %s: %0d expected strobes missing, expected 0", r, q.size());
      end
      q.delete();
   endtask

   task automatic chk_reg(int i, logic [31:0] b, bit v, string r);
      @(negedge clk);
      checks++;
      if (base_f[i*AW +: AW] != b || valid[i] != v) begin
         fails++;
         $display("FAIL %s: region %0d base=%h valid=%0b, expected base=%h valid=%0b",
                  r, i, base_f[i*AW +: AW], valid[i], b, v);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      finish_up();
   end

   initial begin
      // r0 mem 4K, r1 io 256, r2 absent, r3 mem 16, r4 io 32, r5 mem 4K, r6 ROM 64K
      sz[0] = 32'h1000; sz[1] = 32'h100; sz[2] = 32'h0; sz[3] = 32'h10;
      sz[4] = 32'h20;   sz[5] = 32'h1000; sz[6] = 32'h1_0000;
      is_io = 7'b1010010;               // ROM type bit set on purpose (R4)
      for (int k = 0; k < NR; k++) bar[k] = 32'h0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      for (int k = 0; k < NR; k++) chk_reg(k, 32'hFFFF_FFFF, 1'b0, "R1");

      // program with decode off, then enable memory: R2, R11, R5, R4, R8
      step();
      bar[0] = 32'h8000_0123; bar[3] = 32'h4000_0005; bar[5] = 32'h0000_0FFF;
      bar[6] = 32'h000C_0000; bar[2] = 32'h1234_0000;
      settle("R3");
      expect_ev(1, 0, 32'h8000_0000, 0, "R11");
      expect_ev(1, 3, 32'h4000_0000, 0, "R11");
      step(); mem_en = 1'b1;
      settle("R2");
      chk_reg(0, 32'h8000_0000, 1'b1, "R2");
      chk_reg(5, 32'hFFFF_FFFF, 1'b0, "R5");
      chk_reg(2, 32'hFFFF_FFFF, 1'b0, "R8");
      chk_reg(6, 32'hFFFF_FFFF, 1'b0, "R4");

      // ROM enable bit, type bit ignored
      expect_ev(1, 6, 32'h000C_0000, 0, "R4");
      step(); bar[6] = 32'h000C_0001;
      settle("R4");
      chk_reg(6, 32'h000C_0000, 1'b1, "R4");

      // I/O regions: top edge at 0xFFFF maps
      step(); bar[1] = 32'h0000_C001; bar[4] = 32'h0000_FFE0;
      settle("R3");
      expect_ev(1, 1, 32'h0000_C000, 0, "R3");
      expect_ev(1, 4, 32'h0000_FFE0, 0, "R7");
      step(); io_en = 1'b1;
      settle("R7");
      chk_reg(4, 32'h0000_FFE0, 1'b1, "R7");

      // I/O window crossing 0x10000 drops
      expect_ev(0, 4, 32'h0000_FFE0, 0, "R7");
      step(); bar[4] = 32'h0001_0000;
      settle("R7");
      chk_reg(4, 32'hFFFF_FFFF, 1'b0, "R7");

      // low bits inside the mask: no strobe
      step(); bar[0] = 32'h8000_0FFF;
      settle("R10");
      chk_reg(0, 32'h8000_0000, 1'b1, "R10");

      // move: unmap then map next cycle
      expect_ev(0, 0, 32'h8000_0000, 0, "R9");
      expect_ev(1, 0, 32'h9000_0000, 1, "R9");
      step(); bar[0] = 32'h9000_0000;
      settle("R9");
      chk_reg(0, 32'h9000_0000, 1'b1, "R9");

      // memory end at all ones is illegal, one step lower is legal
      step(); bar[5] = 32'hFFFF_F000;
      settle("R6");
      chk_reg(5, 32'hFFFF_FFFF, 1'b0, "R6");
      expect_ev(1, 5, 32'hFFFF_E000, 0, "R6");
      step(); bar[5] = 32'hFFFF_E000;
      settle("R6");

      // size zero region with legal value and decode on stays quiet
      step(); bar[2] = 32'h5000_0000;
      settle("R8");
      chk_reg(2, 32'hFFFF_FFFF, 1'b0, "R8");

      // memory enable off: memory regions release in index order, I/O stays
      expect_ev(0, 0, 32'h9000_0000, 0, "R11");
      expect_ev(0, 3, 32'h4000_0000, 0, "R11");
      expect_ev(0, 5, 32'hFFFF_E000, 0, "R11");
      expect_ev(0, 6, 32'h000C_0000, 0, "R11");
      step(); mem_en = 1'b0;
      settle("R3");
      chk_reg(1, 32'h0000_C000, 1'b1, "R3");

      expect_ev(0, 1, 32'h0000_C000, 0, "R3");
      step(); io_en = 1'b0;
      settle("R3");
      chk_reg(1, 32'hFFFF_FFFF, 1'b0, "R3");

      finish_up();
   end
endmodule